// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block holds the state of a set of interrupt sources and chooses the one to present to a single CPU. Each source has an enable bit, a priority and a CPU-target field. These come in on side-band inputs. The block itself keeps a pending bit and an active bit for each source. Every cycle it scans the sources in ascending ID order. It reports the most urgent eligible source: its ID, its priority and whether the CPU request line is raised.

The CPU acknowledges the presented source through `ackValid`. That source becomes active. It stays pending only if its level input is still high in the acknowledge cycle. A source that is active is never presented again until it is deactivated, even if it is pending again. After an acknowledge, the request therefore moves to another eligible source or drops. The running priority is the most urgent priority among the active sources. It gates preemption, and it reads as all ones when no source is active.

Top module: `intsel_top`

## Requirements
- R1: A source is eligible only when its enable bit is set, its pending bit is set and its active bit is clear.
- R2: Sources with ID below NUM_INTERNAL (8) are eligible whatever their target. A source with a higher ID needs bit CPU_ID (0) of its target field, which sits at `srcTarget[4*id +: 4]`.
- R3: The eligible source with the numerically lowest priority (`srcPrio[8*id +: 8]`) is selected. A tie goes to the lowest ID.
- R4: With no eligible source, `selId` is 1023, `selPrio` is 255 and `irqOut` is low.
- R5: A high `srcLevel` bit makes the source pending from the next cycle. An acknowledge leaves the source active, and pending exactly when its level bit is high in the acknowledge cycle.
- R6: In the cycle after an acknowledge, the acknowledged source is not selected, even if it is still pending.
- R7: `deactValid` with `deactId` below NUM_SRC clears that source's active bit from the next cycle, so it can be selected again if pending. A larger `deactId` has no effect. An acknowledge of the same source in the same cycle wins.
- R8: `irqOut` is high exactly when a source is selected and its priority is numerically below both `prioMask` and the running priority.
- R9: `runPrio` equals the lowest priority value among active sources, or 255 when none is active. For the irqOut comparison, the idle running priority counts as 256.
- R10: `ackValid` while `irqOut` is low changes no state.
- R11: After reset, no source is pending or active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLevel | input | NUM_SRC | Per-source interrupt level |
| srcEnable | input | NUM_SRC | Per-source enable |
| srcPrio | input | NUM_SRC*PRIO_W | Per-source priority, lower is more urgent |
| srcTarget | input | NUM_SRC*NUM_CPU | Per-source CPU target field |
| prioMask | input | PRIO_W | Priority mask threshold |
| ackValid | input | 1 | Acknowledge the presented source |
| deactValid | input | 1 | Deactivate the source named by deactId |
| deactId | input | 10 | Source to deactivate |
| irqOut | output | 1 | CPU interrupt request |
| selId | output | 10 | Selected source ID, 1023 if none |
| selPrio | output | PRIO_W | Priority of the selected source |
| runPrio | output | PRIO_W | Running priority, all ones when idle |

## Verification
Directed cases cover the following:
- an equal-priority tie, which separates the ascending scan from a descending one;
- a shared source whose target omits this CPU, which separates target gating from the internal range;
- a source acknowledged with its line held high, which shows whether active sources are excluded from the scan;
- an out-of-range deactivate and an acknowledge while the request is low, which show that neither changes state.

A long random run then varies levels, enables, coarse priorities (to force many ties), targets and the mask. It compares every output each cycle against a reference scan of a bench-held state model. This catches any ordering, masking or running-priority error that arises only from mixed pending and active patterns.

// File: rtl/intsel_pkg.sv
package intsel_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef struct packed {
    logic            ackFire;
    logic [ID_W-1:0] ackId;
    logic            deactFire;
    logic [ID_W-1:0] deactId;
  } strobe_t;
endpackage

// File: rtl/intsel_datapath.sv
module intsel_datapath
  import intsel_pkg::*;
#(
  parameter int NUM_SRC      = 32,
  parameter int PRIO_W       = 8,
  parameter int NUM_CPU      = 4,
  parameter int NUM_INTERNAL = 8,
  parameter int CPU_ID       = 0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         srcLevel,
  input  logic [NUM_SRC-1:0]         srcEnable,
  input  logic [NUM_SRC*PRIO_W-1:0]  srcPrio,
  input  logic [NUM_SRC*NUM_CPU-1:0] srcTarget,
  input  strobe_t                    strobe,
  output logic                       found,
  output logic [ID_W-1:0]            bestId,
  output logic [PRIO_W-1:0]          bestPrio,
  output logic [PRIO_W:0]            runLvl
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [PRIO_W:0] IDLE_LVL = {1'b1, {PRIO_W{1'b0}}};

  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] activeQ;
  logic [NUM_SRC-1:0] eligible;
  logic [PRIO_W-1:0]  prioArr [NUM_SRC];
  logic [ID_W-1:0]    bestIdx;
  logic [PRIO_W-1:0]  bestP;
  logic [IDX_W-1:0]   ackIdx;
  logic [IDX_W-1:0]   deactIdx;

  assign ackIdx   = strobe.ackId[IDX_W-1:0];
  assign deactIdx = strobe.deactId[IDX_W-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic ackHit;
    logic deactHit;
    logic tgtOk;

    assign ackHit   = strobe.ackFire && (strobe.ackId == ID_W'(i));
    assign deactHit = strobe.deactFire && (strobe.deactId == ID_W'(i));
    assign prioArr[i] = srcPrio[i*PRIO_W +: PRIO_W];

    if (i < NUM_INTERNAL) begin : g_internal
      assign tgtOk = 1'b1;
    end else begin : g_shared
      assign tgtOk = srcTarget[i*NUM_CPU + CPU_ID];
    end

    assign eligible[i] = srcEnable[i] && pendQ[i] && !activeQ[i] && tgtOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[i]   <= 1'b0;
        activeQ[i] <= 1'b0;
      end else begin
        if (ackHit) pendQ[i] <= srcLevel[i];
        else        pendQ[i] <= pendQ[i] | srcLevel[i];
        if (ackHit)        activeQ[i] <= 1'b1;
        else if (deactHit) activeQ[i] <= 1'b0;
      end
    end
  end

  // ascending scan: strictly lower value replaces, so ties keep the lowest ID
  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestP   = '1;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (eligible[k] && (!found || (prioArr[k] < bestP))) begin
        found   = 1'b1;
        bestP   = prioArr[k];
        bestIdx = ID_W'(k);
      end
    end
  end

  always_comb begin
    runLvl = IDLE_LVL;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (activeQ[k] && ({1'b0, prioArr[k]} < runLvl)) runLvl = {1'b0, prioArr[k]};
    end
  end

  assign bestId   = found ? bestIdx : SPURIOUS_ID;
  assign bestPrio = found ? bestP : '1;

  AST_ACK_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackFire |=> activeQ[$past(ackIdx)]); // R5
  AST_ACK_PEND_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackFire |=> (pendQ[$past(ackIdx)] == $past(srcLevel[ackIdx]))); // R5
  AST_NO_RESELECT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackFire |=> !(found && (bestIdx == $past(strobe.ackId)))); // R6
  AST_DEACT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.deactFire && !(strobe.ackFire && (strobe.ackId == strobe.deactId)))
      |=> !activeQ[$past(deactIdx)]); // R7
endmodule

// File: rtl/intsel_ctrl.sv
module intsel_ctrl
  import intsel_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ackValid,
  input  logic              deactValid,
  input  logic [ID_W-1:0]   deactId,
  input  logic              found,
  input  logic [ID_W-1:0]   bestId,
  input  logic [PRIO_W-1:0] bestPrio,
  input  logic [PRIO_W:0]   runLvl,
  input  logic [PRIO_W-1:0] prioMask,
  output logic              irqOut,
  output strobe_t           strobe,
  output logic [PRIO_W-1:0] runPrio
);
  assign irqOut = found && (bestPrio < prioMask) && ({1'b0, bestPrio} < runLvl);

  always_comb begin
    strobe.ackFire   = ackValid && irqOut;
    strobe.ackId     = bestId;
    strobe.deactFire = deactValid && (deactId < ID_W'(NUM_SRC));
    strobe.deactId   = deactId;
  end

  assign runPrio = runLvl[PRIO_W] ? '1 : runLvl[PRIO_W-1:0];

  AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (bestId == SPURIOUS_ID) |-> !irqOut); // R4
  AST_RUN_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackFire |=> (runLvl <= {1'b0, $past(bestPrio)})); // R9
endmodule

// File: rtl/intsel_top.sv
module intsel_top
  import intsel_pkg::*;
#(
  parameter int NUM_SRC      = 32,
  parameter int PRIO_W       = 8,
  parameter int NUM_CPU      = 4,
  parameter int NUM_INTERNAL = 8,
  parameter int CPU_ID       = 0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         srcLevel,
  input  logic [NUM_SRC-1:0]         srcEnable,
  input  logic [NUM_SRC*PRIO_W-1:0]  srcPrio,
  input  logic [NUM_SRC*NUM_CPU-1:0] srcTarget,
  input  logic [PRIO_W-1:0]          prioMask,
  input  logic                       ackValid,
  input  logic                       deactValid,
  input  logic [ID_W-1:0]            deactId,
  output logic                       irqOut,
  output logic [ID_W-1:0]            selId,
  output logic [PRIO_W-1:0]          selPrio,
  output logic [PRIO_W-1:0]          runPrio
);
  strobe_t           strobe;
  logic              found;
  logic [PRIO_W:0]   runLvl;

  intsel_datapath #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .NUM_CPU(NUM_CPU),
    .NUM_INTERNAL(NUM_INTERNAL), .CPU_ID(CPU_ID)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .srcEnable(srcEnable),
    .srcPrio(srcPrio), .srcTarget(srcTarget), .strobe(strobe),
    .found(found), .bestId(selId), .bestPrio(selPrio), .runLvl(runLvl)
  );

  intsel_ctrl #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .ackValid(ackValid), .deactValid(deactValid),
    .deactId(deactId), .found(found), .bestId(selId), .bestPrio(selPrio),
    .runLvl(runLvl), .prioMask(prioMask), .irqOut(irqOut), .strobe(strobe),
    .runPrio(runPrio)
  );
endmodule

// File: tb/test_intsel_top.sv
module test_intsel_top;
  localparam int NS = 32;
  localparam int PW = 8;
  localparam int NC = 4;
  localparam int NI = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0]    srcLevel = '0;
  logic [NS-1:0]    srcEnable = '0;
  logic [NS*PW-1:0] srcPrio = '0;
  logic [NS*NC-1:0] srcTarget = '0;
  logic [PW-1:0]    prioMask = '1;
  logic             ackValid = 1'b0;
  logic             deactValid = 1'b0;
  logic [9:0]       deactId = '0;
  logic             irqOut;
  logic [9:0]       selId;
  logic [PW-1:0]    selPrio;
  logic [PW-1:0]    runPrio;

  int checks = 0;
  int errors = 0;
  logic [NS-1:0] mPend = '0;
  logic [NS-1:0] mAct = '0;

  always #10 clk = ~clk;

  intsel_top i_intsel_top (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .srcEnable(srcEnable),
    .srcPrio(srcPrio), .srcTarget(srcTarget), .prioMask(prioMask),
    .ackValid(ackValid), .deactValid(deactValid), .deactId(deactId),
    .irqOut(irqOut), .selId(selId), .selPrio(selPrio), .runPrio(runPrio)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // check outputs against a reference scan, then advance the model one cycle
  task automatic step(string tag);
    bit f = 0;
    int id = 1023;
    int pr = 255;
    int run = 256;
    bit irq;
    #1;
    for (int k = 0; k < NS; k++) begin
      bit tgt = (k < NI) || srcTarget[k*NC];
      int p = int'(srcPrio[k*PW +: PW]);
      if (srcEnable[k] && mPend[k] && !mAct[k] && tgt && (!f || p < pr)) begin
        f = 1; pr = p; id = k;
      end
      if (mAct[k] && p < run) run = p;
    end
    irq = f && (pr < int'(prioMask)) && (pr < run);
    chk(tag, "selId", int'(selId), id);
    chk(tag, "selPrio", int'(selPrio), pr);
    chk(tag, "irqOut", int'(irqOut), int'(irq));
    chk(tag, "runPrio", int'(runPrio), (run > 255) ? 255 : run);
    for (int k = 0; k < NS; k++) begin
      bit ackHit = ackValid && irq && (id == k);
      mPend[k] = ackHit ? srcLevel[k] : (mPend[k] | srcLevel[k]);
      if (ackHit) mAct[k] = 1'b1;
      else if (deactValid && int'(deactId) == k) mAct[k] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; srcLevel = '0; ackValid = 0; deactValid = 0; prioMask = '1;
    @(posedge clk); @(negedge clk);
    mPend = '0; mAct = '0;
    rstN = 1'b1;
  endtask

  task automatic setPrio(int k, int p);
    srcPrio[k*PW +: PW] = PW'(p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    doReset();
    step("R11");
    srcEnable = '1;
    for (int k = 0; k < NS; k++) setPrio(k, 8'h80);
    step("R4");
    // tie between sources 3 and 5
    srcLevel[3] = 1; srcLevel[5] = 1;
    step("R5");
    srcLevel = '0;
    step("R3");
    setPrio(5, 8'h40);
    step("R3");
    // shared source whose target leaves this CPU out
    doReset();
    srcTarget[12*NC +: NC] = 4'b0010;
    srcLevel[12] = 1;
    step("R2");
    srcLevel = '0;
    step("R2");
    srcTarget[12*NC +: NC] = 4'b0001;
    step("R2");
    // acknowledge with line held high: active and pending, never reselected
    doReset();
    setPrio(2, 8'h10);
    srcLevel[2] = 1;
    step("R5");
    ackValid = 1;
    step("R6");
    ackValid = 0;
    step("R6");
    step("R9");
    deactValid = 1; deactId = 10'd40;
    step("R7");
    deactId = 10'd2;
    step("R7");
    deactValid = 0;
    step("R7");
    srcLevel[2] = 0; ackValid = 1;
    step("R5");
    ackValid = 0;
    step("R5");
    // preemption under the running priority, then masking
    setPrio(9, 8'h08); srcTarget[9*NC] = 1'b1; srcLevel[9] = 1;
    step("R8");
    srcLevel[9] = 0;
    step("R8");
    prioMask = 8'h08;
    ackValid = 1;
    step("R10");
    ackValid = 0;
    step("R10");
    prioMask = '1;
    step("R8");
    deactValid = 1; deactId = 10'd2;
    step("R9");
    deactValid = 0;
    step("R9");
    // random mix
    doReset();
    for (int n = 0; n < 4000; n++) begin
      if (n % 64 == 0) begin
        srcEnable = {$urandom, $urandom} | {$urandom, $urandom};
        srcTarget = {$urandom, $urandom, $urandom, $urandom};
        for (int k = 0; k < NS; k++) setPrio(k, int'($urandom_range(0, 7)) << 5);
        prioMask = ($urandom_range(0, 3) == 0) ? PW'($urandom) : '1;
      end
      srcLevel = $urandom & $urandom & $urandom;
      ackValid = ($urandom_range(0, 9) < 3);
      deactValid = ($urandom_range(0, 9) < 3);
      deactId = 10'($urandom_range(0, 39));
      step("R1");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule